// File: doc/BRIEF.md
# Sequencer Run Controller with Guarded Program Counter

This block decides when a small command sequencer runs, where it fetches from and what it reports. The sequencer reads 32-bit command words from system RAM through an abstract execution unit. This block does not decode commands. It raises `fetch_req` together with the current word address. The execution unit answers with `fetch_ack` for every word it takes. At the end of each command it answers with `cmd_done`, which carries three qualifiers: sleep, opcode error and bus error.

The run enable comes from one of two sources. It is either an external power-controller input or a software bit, and a software mode bit selects between them. When the enable drops, the command already in progress is allowed to finish. The sequencer then parks in a halted state. While the sequencer is halted, software may overwrite the program counter, and execution later resumes from that address. Otherwise every fresh start begins at the supplied base address. A start from the base address is the only event, apart from the self-clearing synchronous reset, that wipes the sticky done and error flags.

Three registers are visible through a simple write strobe and a combinational read port: control, status and program counter. A sleep command sets the done flag and sends a one-cycle pulse to the power controller.

Top module: `seq_run_ctrl`

## Requirements
- R1: The effective enable is control bit 0 when control bit 1 is set, and the `ext_en` input otherwise. When control bit 1 is clear, bit 0 has no effect. A halted sequencer with an effective enable of 1 starts fetching.
- R2: When the effective enable is 0 while a command is in progress (a word was acknowledged and `cmd_done` has not yet arrived), `fetch_req` stays high and the sequencer stays running until `cmd_done`. It halts on that `cmd_done`. With no command in progress, it halts on the next clock.
- R3: Writing control with bit 3 set resets the sequencer on that clock edge. It halts, aborts any command, loads the PC with the base address and clears the done, error and PC-loaded flags. Bit 3 reads back as 1 for one cycle and then reads 0.
- R4: The PC is 32 bits. Bits 1:0 are 0 and bits 31:19 equal 0x400, which places every address in RAM starting at 0x2000_0000. Only bits 18:2 are stored. After reset the PC reads 0x2000_0000, and `fetch_addr` always equals the PC.
- R5: Each acknowledged fetch advances the PC by 4.
- R6: A software write to the PC register (offset 0x8) takes effect only while status bit 5 (stopped) is 1. At any other time it is discarded.
- R7: An accepted PC write sets status bit 6 (PC loaded). The next start clears bit 6 and fetches from the loaded PC rather than from the base address.
- R8: After reset, status reads 0x20, control reads 0, `fetch_req` is 0 and `done_pulse` is 0.
- R9: When a `cmd_done` arrives with `bus_err` set, status bit 3 is set, but only if control bit 2 is 1. When a `cmd_done` arrives with `opcode_err` set, status bit 4 is set. In both cases fetching continues with the next command.
- R10: A `cmd_done` with `is_sleep` set does three things: it sets status bit 2 (done), it raises `done_pulse` for exactly one cycle, and it stops fetching.
- R11: Status bits 2, 3 and 4 are sticky. They clear only on a start from the base address or on a synchronous reset. A start from a loaded PC keeps them.
- R12: The register map is: control at offset 0x0, status at 0x4 and PC at 0x8. Status is read-only, so writes to it are ignored. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| ext_en | input | 1 | Enable from the power controller |
| base_addr | input | 32 | Program start address in RAM |
| fetch_req | output | 1 | Request for the word at `fetch_addr` |
| fetch_addr | output | 32 | Current word address (the PC) |
| fetch_ack | input | 1 | One word taken by the execution unit |
| cmd_done | input | 1 | Current command finished |
| is_sleep | input | 1 | The finished command was a sleep |
| opcode_err | input | 1 | The finished command had a bad opcode |
| bus_err | input | 1 | The finished command hit a bus error |
| done_pulse | output | 1 | One-cycle notice that a sleep command executed |

## Verification
A control write reaches the effective enable on the edge that captures it. A halted sequencer therefore begins fetching one edge after that, which is two edges after the write. The synchronous reset, accepted PC writes, PC steps, flag updates and `done_pulse` all appear one edge after their strobe. The read port follows `reg_addr` without any clock. The bench changes inputs only on falling edges and samples on the falling edge after the rising edge where a result is due. A table walks every combination of the two enable sources. Directed sequences then cover each of these cases:
- a stop in the middle of a command;
- a guarded PC write;
- sticky flags across a loaded and an unloaded restart;
- a sleep;
- a reset that aborts a command.

// File: rtl/seq_run_pkg.sv
package seq_run_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_RUN   = 2'd1,
        ST_SLEEP = 2'd2
    } run_st_e;

    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_STAT = 4'h4;
    localparam logic [3:0] OFS_PC   = 4'h8;

    localparam int CB_EN   = 0;
    localparam int CB_SW   = 1;
    localparam int CB_BED  = 2;
    localparam int CB_SRST = 3;

    localparam int SB_DONE = 2;
    localparam int SB_BUS  = 3;
    localparam int SB_OPC  = 4;
    localparam int SB_STOP = 5;
    localparam int SB_LOAD = 6;

    typedef struct packed {
        logic srst;
        logic bed;
        logic sw;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/seq_ctrl_regs.sv
module seq_ctrl_regs
    import seq_run_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctrl,
    input  logic [3:0] wbits,
    input  logic       ext_en,
    output ctrl_t      ctrl_q,
    output logic       en_eff,
    output logic       srst_stb
);

    ctrl_t ctrl_d;

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.srst = 1'b0;
        if (wr_ctrl) begin
            ctrl_d.en   = wbits[CB_EN];
            ctrl_d.sw   = wbits[CB_SW];
            ctrl_d.bed  = wbits[CB_BED];
            ctrl_d.srst = wbits[CB_SRST];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign srst_stb = wr_ctrl & wbits[CB_SRST];
    assign en_eff   = ctrl_q.sw ? ctrl_q.en : ext_en;

    // R3: the reset bit never survives two cycles
    a_r3_srst_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.srst && !srst_stb) |=> !ctrl_q.srst);

endmodule

// File: rtl/seq_pc_unit.sv
module seq_pc_unit #(
    parameter int PC_W = 17
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] rst_bits,
    input  logic            base_ld,
    input  logic [PC_W-1:0] base_bits,
    input  logic            pc_ld,
    input  logic [PC_W-1:0] ld_bits,
    input  logic            pc_step,
    output logic [PC_W-1:0] pc_q
);

    logic [PC_W-1:0] pc_d;

    always_comb begin
        pc_d = pc_q;
        if (base_ld)      pc_d = base_bits;
        else if (pc_ld)   pc_d = ld_bits;
        else if (pc_step) pc_d = pc_q + PC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= rst_bits;
        else        pc_q <= pc_d;
    end

    // R5: one word step per acknowledged fetch
    a_r5_step_by_word: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_step && !base_ld && !pc_ld) |=> (pc_q == $past(pc_q) + PC_W'(1)));

    // R6: without a load, step or base reload the PC holds
    a_r6_pc_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!pc_step && !base_ld && !pc_ld) |=> $stable(pc_q));

endmodule

// File: rtl/seq_run_fsm.sv
module seq_run_fsm
    import seq_run_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_eff,
    input  logic srst,
    input  logic bus_det_en,
    input  logic pc_wr,
    input  logic fetch_ack,
    input  logic cmd_done,
    input  logic is_sleep,
    input  logic opcode_err,
    input  logic bus_err,
    output logic fetch_req,
    output logic base_ld,
    output logic pc_ld,
    output logic pc_step,
    output logic flag_done,
    output logic flag_bus,
    output logic flag_opc,
    output logic flag_stop,
    output logic flag_load,
    output logic done_pulse
);

    typedef struct packed {
        run_st_e st;
        logic    act;
        logic    done;
        logic    berr;
        logic    oerr;
        logic    loaded;
        logic    dpulse;
    } fsm_t;

    fsm_t s_q, s_d;

    always_comb begin
        s_d        = s_q;
        s_d.dpulse = 1'b0;
        base_ld    = 1'b0;
        pc_ld      = 1'b0;
        if (srst) begin
            s_d.st     = ST_HALT;
            s_d.act    = 1'b0;
            s_d.done   = 1'b0;
            s_d.berr   = 1'b0;
            s_d.oerr   = 1'b0;
            s_d.loaded = 1'b0;
            base_ld    = 1'b1;
        end else begin
            case (s_q.st)
                ST_HALT: begin
                    if (en_eff) begin
                        s_d.st     = ST_RUN;
                        s_d.loaded = 1'b0;
                        if (!s_q.loaded) begin
                            base_ld  = 1'b1;
                            s_d.done = 1'b0;
                            s_d.berr = 1'b0;
                            s_d.oerr = 1'b0;
                        end
                    end else if (pc_wr) begin
                        pc_ld      = 1'b1;
                        s_d.loaded = 1'b1;
                    end
                end
                ST_RUN: begin
                    s_d.act = (s_q.act | fetch_ack) & ~cmd_done;
                    if (cmd_done && bus_err && bus_det_en) s_d.berr = 1'b1;
                    if (cmd_done && opcode_err)            s_d.oerr = 1'b1;
                    if (cmd_done && is_sleep) begin
                        s_d.done   = 1'b1;
                        s_d.dpulse = 1'b1;
                        s_d.st     = ST_SLEEP;
                    end else if (!en_eff && (cmd_done || (!s_q.act && !fetch_ack))) begin
                        s_d.st = ST_HALT;
                    end
                end
                ST_SLEEP: begin
                    if (!en_eff) s_d.st = ST_HALT;
                end
                default: s_d.st = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st     <= ST_HALT;
            s_q.act    <= 1'b0;
            s_q.done   <= 1'b0;
            s_q.berr   <= 1'b0;
            s_q.oerr   <= 1'b0;
            s_q.loaded <= 1'b0;
            s_q.dpulse <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign fetch_req  = (s_q.st == ST_RUN) && (en_eff || s_q.act);
    assign pc_step    = fetch_req & fetch_ack;
    assign flag_done  = s_q.done;
    assign flag_bus   = s_q.berr;
    assign flag_opc   = s_q.oerr;
    assign flag_stop  = (s_q.st == ST_HALT);
    assign flag_load  = s_q.loaded;
    assign done_pulse = s_q.dpulse;

    // R2: an unfinished command keeps the sequencer running
    a_r2_no_halt_mid_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RUN && s_q.act && !cmd_done && !srst) |=> (s_q.st == ST_RUN));

    // R10: done pulse is a single cycle and arrives with the done flag
    a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.dpulse |=> !s_q.dpulse);
    a_r10_pulse_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.dpulse |-> s_q.done);

    // R7: the loaded flag rises only out of the halted state
    a_r7_load_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.loaded) |-> ($past(s_q.st) == ST_HALT));

    // R11: sticky flags survive everything except a base restart or reset
    a_r11_bus_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.berr && !base_ld) |=> s_q.berr);
    a_r11_opc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.oerr && !base_ld) |=> s_q.oerr);
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && !base_ld) |=> s_q.done);

endmodule

// File: rtl/seq_run_ctrl.sv
module seq_run_ctrl
    import seq_run_pkg::*;
#(
    parameter int          ADDR_W   = 32,
    parameter int          PC_LO    = 2,
    parameter int          PC_HI    = 18,
    parameter logic [31:0] RAM_BASE = 32'h2000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ext_en,
    input  logic [31:0] base_addr,
    output logic        fetch_req,
    output logic [31:0] fetch_addr,
    input  logic        fetch_ack,
    input  logic        cmd_done,
    input  logic        is_sleep,
    input  logic        opcode_err,
    input  logic        bus_err,
    output logic        done_pulse
);

    localparam int PC_W  = PC_HI - PC_LO + 1;
    localparam int TOP_W = ADDR_W - PC_HI - 1;

    ctrl_t           ctrl_q;
    logic            en_eff, srst_stb;
    logic            wr_ctrl, wr_pc;
    logic            base_ld, pc_ld, pc_step;
    logic            f_done, f_bus, f_opc, f_stop, f_load;
    logic [PC_W-1:0] pc_q;
    logic            unused_bits;

    assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
    assign wr_pc   = reg_wr && (reg_addr == OFS_PC);

    seq_ctrl_regs u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .wbits    (reg_wdata[3:0]),
        .ext_en   (ext_en),
        .ctrl_q   (ctrl_q),
        .en_eff   (en_eff),
        .srst_stb (srst_stb)
    );

    seq_run_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_eff     (en_eff),
        .srst       (srst_stb),
        .bus_det_en (ctrl_q.bed),
        .pc_wr      (wr_pc),
        .fetch_ack  (fetch_ack),
        .cmd_done   (cmd_done),
        .is_sleep   (is_sleep),
        .opcode_err (opcode_err),
        .bus_err    (bus_err),
        .fetch_req  (fetch_req),
        .base_ld    (base_ld),
        .pc_ld      (pc_ld),
        .pc_step    (pc_step),
        .flag_done  (f_done),
        .flag_bus   (f_bus),
        .flag_opc   (f_opc),
        .flag_stop  (f_stop),
        .flag_load  (f_load),
        .done_pulse (done_pulse)
    );

    seq_pc_unit #(.PC_W(PC_W)) u_pc (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_bits  (RAM_BASE[PC_HI:PC_LO]),
        .base_ld   (base_ld),
        .base_bits (base_addr[PC_HI:PC_LO]),
        .pc_ld     (pc_ld),
        .ld_bits   (reg_wdata[PC_HI:PC_LO]),
        .pc_step   (pc_step),
        .pc_q      (pc_q)
    );

    assign fetch_addr = {RAM_BASE[ADDR_W-1 -: TOP_W], pc_q, {PC_LO{1'b0}}};

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: reg_rdata[3:0] = ctrl_q;
            OFS_STAT: begin
                reg_rdata[SB_DONE] = f_done;
                reg_rdata[SB_BUS]  = f_bus;
                reg_rdata[SB_OPC]  = f_opc;
                reg_rdata[SB_STOP] = f_stop;
                reg_rdata[SB_LOAD] = f_load;
            end
            OFS_PC:   reg_rdata = fetch_addr;
            default:  reg_rdata = '0;
        endcase
    end

    assign unused_bits = ^{reg_wdata[31:PC_HI+1], base_addr[31:PC_HI+1],
                           base_addr[PC_LO-1:0], reg_wdata[PC_LO-1:0]};

    // R6: a PC load is only ever issued while halted
    a_r6_load_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        pc_ld |-> (f_stop && wr_pc));

    // R4: fixed address bits never move
    a_r4_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (fetch_addr[31:19] == 13'h400 && fetch_addr[1:0] == 2'b00));

endmodule

// File: tb/test_seq_run_ctrl.sv
module test_seq_run_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ext_en = 1'b0;
    logic [31:0] base_addr = 32'h2000_0100;
    logic        fetch_req;
    logic [31:0] fetch_addr;
    logic        fetch_ack = 1'b0;
    logic        cmd_done = 1'b0;
    logic        is_sleep = 1'b0;
    logic        opcode_err = 1'b0;
    logic        bus_err = 1'b0;
    logic        done_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    seq_run_ctrl i_seq_run_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_en(ext_en),
        .base_addr(base_addr), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ack(fetch_ack), .cmd_done(cmd_done), .is_sleep(is_sleep),
        .opcode_err(opcode_err), .bus_err(bus_err), .done_pulse(done_pulse)
    );

    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_STAT = 4'h4;
    localparam logic [3:0] A_PC   = 4'h8;
    localparam logic [31:0] BASE  = 32'h2000_0100;

    // {sw, en, ext, expected effective enable}
    localparam logic [3:0] EN_TAB [8] = '{
        4'b0000, 4'b0011, 4'b0100, 4'b0111,
        4'b1000, 4'b1010, 4'b1101, 4'b1111
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic cyc(input logic ack, input logic dn, input logic slp,
                       input logic oe, input logic be);
        fetch_ack = ack; cmd_done = dn; is_sleep = slp; opcode_err = oe; bus_err = be;
        tick();
        fetch_ack = 1'b0; cmd_done = 1'b0; is_sleep = 1'b0; opcode_err = 1'b0; bus_err = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [31:0] v;
        tick();
        tick();
        // R8 reset state
        rd(A_STAT, v); chk("R8 status", v, 32'h20);
        rd(A_CTRL, v); chk("R8 ctrl", v, 32'h0);
        chk("R8 fetch_req", {31'b0, fetch_req}, 32'd0);
        chk("R8 done_pulse", {31'b0, done_pulse}, 32'd0);
        rd(A_PC, v);   chk("R4 reset pc", v, 32'h2000_0000);
        rst_n = 1'b1;
        tick();

        // R1 enable selection table
        for (int i = 0; i < 8; i++) begin
            ext_en = EN_TAB[i][1];
            wr(A_CTRL, {28'b0, 1'b1, 1'b0, EN_TAB[i][3], EN_TAB[i][2]});
            tick();
            chk("R1 fetch_req", {31'b0, fetch_req}, {31'b0, EN_TAB[i][0]});
            rd(A_STAT, v);
            chk("R1 stopped", {31'b0, v[5]}, {31'b0, ~EN_TAB[i][0]});
        end

        // start from base
        ext_en = 1'b0;
        wr(A_CTRL, 32'h0B);
        tick();
        chk("R4 start addr", fetch_addr, BASE);
        cyc(1, 0, 0, 0, 0);
        chk("R5 step", fetch_addr, BASE + 4);
        // R6 write while running is discarded
        wr(A_PC, 32'h2000_0800);
        rd(A_PC, v); chk("R6 ignored", v, BASE + 4);
        rd(A_STAT, v); chk("R6 no load flag", v, 32'h0);
        cyc(0, 1, 0, 0, 0);
        cyc(1, 0, 0, 0, 0);
        chk("R5 step2", fetch_addr, BASE + 8);

        // R2 stop waits for command end
        wr(A_CTRL, 32'h02);
        chk("R2 still fetching", {31'b0, fetch_req}, 32'd1);
        tick(); tick();
        rd(A_STAT, v); chk("R2 not stopped", v, 32'h0);
        cyc(0, 1, 0, 0, 0);
        rd(A_STAT, v); chk("R2 stopped", v, 32'h20);
        chk("R2 fetch_req off", {31'b0, fetch_req}, 32'd0);

        // R6/R7 accepted write while halted
        wr(A_PC, 32'h2000_0040);
        rd(A_PC, v); chk("R6 accepted", v, 32'h2000_0040);
        rd(A_STAT, v); chk("R7 load flag", v, 32'h60);
        wr(A_CTRL, 32'h03);
        tick();
        chk("R7 resume addr", fetch_addr, 32'h2000_0040);
        rd(A_STAT, v); chk("R7 load cleared", v, 32'h0);

        // R9 errors
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 1);
        rd(A_STAT, v); chk("R9 bus masked", v, 32'h0);
        chk("R9 continues", {31'b0, fetch_req}, 32'd1);
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 0, 1, 0);
        rd(A_STAT, v); chk("R9 opcode flag", v, 32'h10);
        wr(A_CTRL, 32'h07);
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 1);
        rd(A_STAT, v); chk("R9 bus flag", v, 32'h18);
        chk("R9 next addr", fetch_addr, 32'h2000_004C);

        // R11 flags kept across loaded restart
        wr(A_CTRL, 32'h06);
        tick();
        rd(A_STAT, v); chk("R11 halted", v, 32'h38);
        wr(A_PC, 32'h2000_0200);
        wr(A_CTRL, 32'h07);
        tick();
        rd(A_STAT, v); chk("R11 kept", v, 32'h18);
        chk("R11 loaded addr", fetch_addr, 32'h2000_0200);
        wr(A_CTRL, 32'h06);
        tick();
        wr(A_CTRL, 32'h07);
        tick();
        rd(A_STAT, v); chk("R11 cleared", v, 32'h0);
        chk("R11 base addr", fetch_addr, BASE);

        // R10 sleep
        cyc(1, 0, 0, 0, 0);
        cyc(0, 1, 1, 0, 0);
        chk("R10 pulse", {31'b0, done_pulse}, 32'd1);
        chk("R10 fetch off", {31'b0, fetch_req}, 32'd0);
        rd(A_STAT, v); chk("R10 done flag", v, 32'h04);
        tick();
        chk("R10 pulse ends", {31'b0, done_pulse}, 32'd0);
        rd(A_STAT, v); chk("R10 done sticky", v, 32'h04);

        // R3 synchronous reset
        wr(A_CTRL, 32'h0F);
        rd(A_STAT, v); chk("R3 status", v, 32'h20);
        rd(A_PC, v);   chk("R3 pc base", v, BASE);
        rd(A_CTRL, v); chk("R3 bit held", v, 32'h0F);
        tick();
        rd(A_CTRL, v); chk("R3 bit cleared", v, 32'h07);
        chk("R3 restart", fetch_addr, BASE);
        cyc(1, 0, 0, 0, 0);
        wr(A_CTRL, 32'h0F);
        chk("R3 abort", {31'b0, fetch_req}, 32'd0);
        rd(A_PC, v); chk("R3 abort pc", v, BASE);
        tick();
        chk("R3 rerun", {31'b0, fetch_req}, 32'd1);

        // R12 map
        wr(A_STAT, 32'hFF);
        rd(A_STAT, v); chk("R12 status ro", v, 32'h0);
        rd(4'hC, v);   chk("R12 unmapped", v, 32'h0);

        finished = 1'b1;
        summary();
    end

endmodule